// File: doc/BRIEF.md
# Pseudorandom Shift-Register Sequence Generator

This block produces a pseudorandom bit stream and a pseudorandom word from a left-shifting linear feedback shift register. On every enabled clock cycle the register moves one place toward its most significant end. The bit that enters at the least significant end is the XOR of a fixed set of tap bits. The full register word and the bit that leaves at the top are both brought out, so the block can feed a parallel consumer or a serial one.

The `WIDTH` parameter picks the tap set when the design is elaborated. With 32 bits, and the bits numbered 1 (LSB) up to 32 (MSB), the taps are bits 32, 22, 2 and 1. With 3 bits the taps are bits 3 and 2. The 3-bit build is short enough to check its whole cycle by hand. The order of states is fixed, so a seed only chooses the point in the cycle where the sequence starts. The all-zero state would lock the register, so a zero seed is replaced with all ones. Reset loads all ones as well.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the register leaves reset a few clock edges after `rst_n` goes high. A seed load takes priority over a shift in the same cycle.

Top module: `prng_lfsr`

## Requirements
- R1: While `rst_n` is low, `state` is all ones and `serial_out` is 1, and this takes effect without waiting for a clock edge. After release, all ones remains the state until the first enabled shift.
- R2: With `WIDTH`=32, an edge with `en`=1 and `seed_load`=0 turns state S into {S[30:0], S[31]^S[21]^S[1]^S[0]}. Bit indices here count from 0 at the LSB, so these are taps 32, 22, 2 and 1.
- R3: An edge with `en`=0 and `seed_load`=0 leaves `state` unchanged.
- R4: An edge with `seed_load`=1 and a nonzero `seed` makes `state` equal to `seed`, whatever the value of `en`.
- R5: An edge with `seed_load`=1 and `seed`=0 makes `state` all ones.
- R6: `serial_out` always equals the current MSB of `state`, which is the bit the next shift pushes out.
- R7: With `WIDTH`=3, the feedback is bit 2 XOR bit 1 (0-indexed). Starting from 7, successive enabled shifts give 6, 4, 1, 2, 5, 3 and then 7 again, a period of 7.
- R8: A seed only sets the starting point in the cycle. With `WIDTH`=3, loading 5 and then shifting gives 3, 7, 6, 4, 1, 2, 5.
- R9: Once reset has been released, `state` is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Shift enable |
| seed_load | input | 1 | Load `seed` into the register on this edge, overriding `en` |
| seed | input | WIDTH | Seed value; zero is replaced by all ones |
| state | output | WIDTH | Current register contents |
| serial_out | output | 1 | MSB of the register, the bit shifted out next |

## Verification
A wrong tap or a wrong shift direction shows up on `state` one edge after the first enabled shift. From then on the stream differs from the reference sequence, so a 32-bit run compared against the reference at every step catches it within a few cycles. A broken zero guard or a stuck state would leave `state` at zero or unchanged, and this shows on the edge right after the bad load or the first ignored shift. A serial tap taken from the wrong bit differs from the MSB of `state` as soon as those two bits differ, which happens within the first handful of shifts from all ones.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  localparam int MAX_WIDTH = 64;

  // Tap mask for a given register width, 0-indexed (bit k here is tap k+1).
  function automatic logic [MAX_WIDTH-1:0] tap_mask(input int width);
    logic [MAX_WIDTH-1:0] m;
    m = '0;
    case (width)
      32: begin
        m[31] = 1'b1;
        m[21] = 1'b1;
        m[1]  = 1'b1;
        m[0]  = 1'b1;
      end
      3: begin
        m[2] = 1'b1;
        m[1] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lfsr_rst_sync.sv
module lfsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/lfsr_feedback.sv
module lfsr_feedback
  import lfsr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] cur,
  output logic             fb
);

  localparam logic [MAX_WIDTH-1:0] FULL_MASK = tap_mask(WIDTH);
  localparam logic [WIDTH-1:0]     TAPS      = FULL_MASK[WIDTH-1:0];

  logic [WIDTH:0] chain;

  assign chain[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_tap
      if (TAPS[gi]) begin : g_on
        assign chain[gi+1] = chain[gi] ^ cur[gi];
      end else begin : g_off
        assign chain[gi+1] = chain[gi];
      end
    end
  endgenerate

  assign fb = chain[WIDTH];

endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] seed_in,
  output logic [WIDTH-1:0] seed_safe
);

  localparam logic [WIDTH-1:0] DEFAULT_SEED = '1;

  always_comb begin
    if (seed_in == '0) begin
      seed_safe = DEFAULT_SEED;
    end else begin
      seed_safe = seed_in;
    end
  end

  // R5
  always_comb begin
    guard_nonzero_chk: assert (seed_safe != '0);
  end

endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             fb,
  output logic [WIDTH-1:0] state_q
);

  localparam logic [WIDTH-1:0] RESET_VAL = '1;

  logic [WIDTH-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (load) begin
      state_d = load_val;
    end else if (en) begin
      state_d = {state_q[WIDTH-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RESET_VAL;
    end else if (load || en) begin
      state_q <= state_d;
    end
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(state_q));

  // R2
  shift_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> (state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0])));

  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state_q == $past(load_val)));

  // R9
  never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/prng_lfsr.sv
module prng_lfsr #(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state,
  output logic             serial_out
);

  logic             srst_n;
  logic             fb;
  logic [WIDTH-1:0] seed_safe;
  logic [WIDTH-1:0] state_q;

  lfsr_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  lfsr_feedback #(
    .WIDTH (WIDTH)
  ) u_feedback (
    .cur (state_q),
    .fb  (fb)
  );

  lfsr_seed_guard #(
    .WIDTH (WIDTH)
  ) u_seed_guard (
    .seed_in   (seed),
    .seed_safe (seed_safe)
  );

  lfsr_state_reg #(
    .WIDTH (WIDTH)
  ) u_state_reg (
    .clk      (clk),
    .rst_n    (srst_n),
    .en       (en),
    .load     (seed_load),
    .load_val (seed_safe),
    .fb       (fb),
    .state_q  (state_q)
  );

  assign state      = state_q;
  assign serial_out = state_q[WIDTH-1];

  // R5
  zero_seed_default_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (seed_load && (seed == '0)) |=> (state == '1));

  // R4
  load_over_shift_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (seed_load && en && (seed != '0)) |=> (state == $past(seed)));

endmodule

// File: tb/test_prng_lfsr.sv
module test_prng_lfsr;

  localparam int CLK_PERIOD = 10;
  localparam int W32 = 32;
  localparam int W3  = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic en32, ld32, en3, ld3;
  logic [W32-1:0] seed32;
  logic [W3-1:0]  seed3;
  logic [W32-1:0] st32;
  logic [W3-1:0]  st3;
  logic ser32, ser3;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prng_lfsr #(.WIDTH(W32)) i_prng_lfsr (
    .clk(clk), .rst_n(rst_n), .en(en32), .seed_load(ld32), .seed(seed32),
    .state(st32), .serial_out(ser32)
  );

  prng_lfsr #(.WIDTH(W3)) i_prng_lfsr_w3 (
    .clk(clk), .rst_n(rst_n), .en(en3), .seed_load(ld3), .seed(seed3),
    .state(st3), .serial_out(ser3)
  );

  function automatic logic [31:0] ref_next32(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic e32, input logic l32, input logic [31:0] s32,
                      input logic e3, input logic l3, input logic [2:0] s3);
    en32 = e32; ld32 = l32; seed32 = s32;
    en3 = e3; ld3 = l3; seed3 = s3;
    @(negedge clk);
    en32 = 1'b0; ld32 = 1'b0; en3 = 1'b0; ld3 = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    en32 = 1'b0; ld32 = 1'b0; seed32 = '0;
    en3 = 1'b0; ld3 = 1'b0; seed3 = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state32", st32, 32'hFFFF_FFFF);
    check("R1 reset state3", {29'd0, st3}, 32'd7);
    check("R1 reset serial", {31'd0, ser32}, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 post-release state32", st32, 32'hFFFF_FFFF);
    check("R1 post-release state3", {29'd0, st3}, 32'd7);
  endtask

  task automatic t_seq3();
    logic [2:0] exp_seq [7] = '{3'd6, 3'd4, 3'd1, 3'd2, 3'd5, 3'd3, 3'd7};
    for (int i = 0; i < 7; i++) begin
      step(1'b0, 1'b0, '0, 1'b1, 1'b0, '0);
      check("R7 sequence3", {29'd0, st3}, {29'd0, exp_seq[i]});
    end
    check("R6 serial3", {31'd0, ser3}, {31'd0, st3[2]});
  endtask

  task automatic t_seed3();
    logic [2:0] exp_seq [7] = '{3'd3, 3'd7, 3'd6, 3'd4, 3'd1, 3'd2, 3'd5};
    step(1'b0, 1'b0, '0, 1'b0, 1'b1, 3'd5);
    check("R8 seed3 load", {29'd0, st3}, 32'd5);
    for (int i = 0; i < 7; i++) begin
      step(1'b0, 1'b0, '0, 1'b1, 1'b0, '0);
      check("R8 seeded sequence3", {29'd0, st3}, {29'd0, exp_seq[i]});
    end
  endtask

  task automatic t_shift32();
    logic [31:0] exp;
    exp = st32;
    for (int i = 0; i < 3000; i++) begin
      step(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
      exp = ref_next32(exp);
      check("R2 shift32", st32, exp);
      check("R6 serial32", {31'd0, ser32}, {31'd0, exp[31]});
      if (st32 == '0) check("R9 nonzero32", st32, 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_hold();
    logic [31:0] h32;
    logic [2:0]  h3;
    h32 = st32; h3 = st3;
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, 32'h1234_5678, 1'b0, 1'b0, 3'd2);
      check("R3 hold32", st32, h32);
      check("R3 hold3", {29'd0, st3}, {29'd0, h3});
    end
  endtask

  task automatic t_load();
    step(1'b1, 1'b1, 32'h0000_0001, 1'b1, 1'b1, 3'd1);
    check("R4 load beats shift32", st32, 32'h0000_0001);
    check("R4 load beats shift3", {29'd0, st3}, 32'd1);
    check("R6 serial after load", {31'd0, ser32}, 32'd0);
    step(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
    check("R2 shift from one", st32, 32'h0000_0003);
    step(1'b0, 1'b1, 32'h8020_0000, 1'b0, 1'b0, '0);
    check("R4 load32", st32, 32'h8020_0000);
    step(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
    check("R2 upper taps", st32, 32'h0040_0000);
  endtask

  task automatic t_zero();
    step(1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 3'd0);
    check("R5 zero seed32", st32, 32'hFFFF_FFFF);
    check("R5 zero seed3", {29'd0, st3}, 32'd7);
    step(1'b1, 1'b1, 32'h0, 1'b1, 1'b1, 3'd0);
    check("R5 zero seed with en32", st32, 32'hFFFF_FFFF);
    check("R9 nonzero3", {31'd0, (st3 != 3'd0)}, 32'd1);
  endtask

  task automatic t_async_reset();
    step(1'b1, 1'b0, '0, 1'b1, 1'b0, '0);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R1 async reset32", st32, 32'hFFFF_FFFF);
    check("R1 async reset3", {29'd0, st3}, 32'd7);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reassert", st32, 32'hFFFF_FFFF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_seq3();
    t_seed3();
    t_shift32();
    t_hold();
    t_load();
    t_zero();
    t_async_reset();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

endmodule